// File: doc/BRIEF.md
# Inline VGA Retiming Buffer

This block sits in the path of a VGA video stream. It reads the horizontal and vertical syncs of the incoming signal, rebuilds the input row and column from them, and regenerates a clean outgoing sync train that runs a fixed number of clocks behind the input. Pixels of the input's visible area go into a small queue. They leave the queue when the outgoing timing reaches the same pixel position, so the output is a delayed copy of the input image. The queue covers the gap between the two timings, so pixels that arrive while the output sits in porch or sync wait there until the output's visible area opens.

The block needs one falling vertical sync to lock. Everything it receives before that point is thrown away, and the outgoing syncs stay idle until then. After lock, any sign that the two timings have come apart raises a sticky error flag. These signs are a missing horizontal sync, a missing vertical sync, a write into a full queue or a read from an empty one. Only reset clears the flag.

A line runs in the order sync, back porch, visible, front porch, and its length is counted from the falling edge of the horizontal sync. A frame is ordered the same way in lines, counted from the falling edge of the vertical sync. The defaults describe a 640x480 picture with an 800-clock line and a 525-line frame.

Top module: `ivga_retimer`

## Requirements
- R1: While reset is low, and after its release until lock, the outputs are idle: `o_hsync` and `o_vsync` are 1, `o_red`, `o_green` and `o_blue` are 0, and `o_error` is 0.
- R2: Nothing received before the first falling edge of `i_vsync` is forwarded. Until that edge has passed through the pipeline, the syncs stay high and the colour outputs stay zero.
- R3: After lock, `o_hsync` and `o_vsync` reproduce the input sync waveforms delayed by exactly OFFSET+1 clocks. `o_hsync` is low for H_SYNC clocks of every H_TOTAL clock line. `o_vsync` is low for V_SYNC whole lines, and it falls together with `o_hsync`.
- R4: A pixel sits on the 9-bit colour input (3 bits each for red, green and blue) at line position H_SYNC+H_BP+x of line V_SYNC+V_BP+y. Position 0 is the clock where `i_hsync` is first low, and line 0 is the line where `i_vsync` is first low. If x < H_VIS and y < V_VIS, the pixel appears unchanged on the colour outputs OFFSET+1 clocks later, and pixels keep their order.
- R5: Outside the visible area of the output timing, including its sync pulses, the colour outputs are 0 whatever is driven on the colour inputs.
- R6: After lock, if no falling edge of `i_hsync` arrives H_TOTAL clocks after the previous one, `o_error` rises.
- R7: After lock, if a falling edge of `i_hsync` starts a line V_TOTAL lines after the last falling edge of `i_vsync`, and `i_vsync` does not fall with it, `o_error` rises.
- R8: A queue write while the queue is full and no read happens, or a queue read while the queue is empty, raises `o_error`. Input lines that are too short cause such a write.
- R9: Once `o_error` is 1 it stays 1 whatever the inputs do, until `rst_n` goes low, which clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| i_red | input | 3 | Incoming red value |
| i_green | input | 3 | Incoming green value |
| i_blue | input | 3 | Incoming blue value |
| i_hsync | input | 1 | Incoming horizontal sync, active low |
| i_vsync | input | 1 | Incoming vertical sync, active low |
| o_red | output | 3 | Outgoing red value |
| o_green | output | 3 | Outgoing green value |
| o_blue | output | 3 | Outgoing blue value |
| o_hsync | output | 1 | Outgoing horizontal sync, active low |
| o_vsync | output | 1 | Outgoing vertical sync, active low |
| o_error | output | 1 | Sticky error flag |

## Verification
A wrong input column or row counter shifts which pixels enter the queue. This shows within one visible line as a pixel offset on the colour outputs, and soon after as an underflow or overflow on `o_error`. A wrong output counter shows on the next sync pulse as an `o_hsync` or `o_vsync` edge that arrives off the fixed delay, or as colour where zero belongs. A corrupted queue pointer or count changes the pixel values or their order at the first visible pixel of the next row. A lock flag set too early lets data from the first, discarded frame reach the outputs.

// File: rtl/ivga_pkg.sv
package ivga_pkg;

  // one pixel: three bits per colour channel
  typedef struct packed {
    logic [2:0] r;
    logic [2:0] g;
    logic [2:0] b;
  } pix_t;

endpackage

// File: rtl/ivga_src_track.sv
// Follows the incoming sync train: edge detect, line/column counters,
// lock on the first vertical sync and detection of missing syncs.
module ivga_src_track
  import ivga_pkg::*;
#(
  parameter int H_SYNC  = 96,
  parameter int H_BP    = 48,
  parameter int H_VIS   = 640,
  parameter int H_TOTAL = 800,
  parameter int V_SYNC  = 2,
  parameter int V_BP    = 33,
  parameter int V_VIS   = 480,
  parameter int V_TOTAL = 525
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hsync_in,
  input  logic vsync_in,
  input  pix_t pix_in,
  output pix_t pix_q,
  output logic vis,
  output logic lock_evt,
  output logic locked,
  output logic lost
);

  localparam int HW = $clog2(H_TOTAL + 1);
  localparam int VW = $clog2(V_TOTAL + 1);
  localparam logic [HW-1:0] H_ON  = HW'(H_SYNC + H_BP);
  localparam logic [HW-1:0] H_OFF = HW'(H_SYNC + H_BP + H_VIS);
  localparam logic [HW-1:0] H_END = HW'(H_TOTAL);
  localparam logic [VW-1:0] V_ON  = VW'(V_SYNC + V_BP);
  localparam logic [VW-1:0] V_OFF = VW'(V_SYNC + V_BP + V_VIS);
  localparam logic [VW-1:0] V_LST = VW'(V_TOTAL - 1);

  logic          hs_s1, hs_s2, vs_s1, vs_s2;
  logic [HW-1:0] hcnt, hcnt_d;
  logic [VW-1:0] vcnt, vcnt_d;
  logic          vcnt_en, locked_d;
  logic          hfall, vfall;

  assign hfall = hs_s2 & ~hs_s1;
  assign vfall = vs_s2 & ~vs_s1;

  always_comb begin
    // column restarts at 1 so that hcnt names the position held in pix_q
    if (hfall)             hcnt_d = HW'(1);
    else if (hcnt == H_END) hcnt_d = hcnt;
    else                   hcnt_d = hcnt + 1'b1;
    vcnt_en  = hfall | vfall;
    vcnt_d   = vfall ? '0 : vcnt + 1'b1;
    locked_d = locked | vfall;
  end

  assign lock_evt = vfall & ~locked;
  assign vis  = locked & (hcnt >= H_ON) & (hcnt < H_OFF)
                       & (vcnt >= V_ON) & (vcnt < V_OFF);
  assign lost = locked & (((hcnt == H_END) & ~hfall)
                        | (hfall & ~vfall & (vcnt == V_LST)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_s1  <= 1'b1;
      hs_s2  <= 1'b1;
      vs_s1  <= 1'b1;
      vs_s2  <= 1'b1;
      pix_q  <= '0;
      hcnt   <= '0;
      vcnt   <= '0;
      locked <= 1'b0;
    end else begin
      hs_s1  <= hsync_in;
      hs_s2  <= hs_s1;
      vs_s1  <= vsync_in;
      vs_s2  <= vs_s1;
      pix_q  <= pix_in;
      hcnt   <= hcnt_d;
      if (vcnt_en) vcnt <= vcnt_d;
      locked <= locked_d;
    end
  end

endmodule

// File: rtl/ivga_out_timing.sv
// Free-running outgoing timing, started once at lock with a fixed lag.
module ivga_out_timing #(
  parameter int H_SYNC  = 96,
  parameter int H_BP    = 48,
  parameter int H_VIS   = 640,
  parameter int H_TOTAL = 800,
  parameter int V_SYNC  = 2,
  parameter int V_BP    = 33,
  parameter int V_VIS   = 480,
  parameter int V_TOTAL = 525,
  parameter int OFFSET  = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic hs_n,
  output logic vs_n,
  output logic vis
);

  localparam int HW = $clog2(H_TOTAL);
  localparam int VW = $clog2(V_TOTAL);
  // the clock after lock is input position 1, so the output sits OFFSET behind
  localparam logic [HW-1:0] H_INIT = HW'((H_TOTAL + 1 - OFFSET) % H_TOTAL);
  localparam logic [VW-1:0] V_INIT = (OFFSET == 1) ? '0 : VW'(V_TOTAL - 1);
  localparam logic [HW-1:0] H_LST  = HW'(H_TOTAL - 1);
  localparam logic [VW-1:0] V_LST  = VW'(V_TOTAL - 1);
  localparam logic [HW-1:0] H_SW   = HW'(H_SYNC);
  localparam logic [VW-1:0] V_SW   = VW'(V_SYNC);
  localparam logic [HW-1:0] H_ON   = HW'(H_SYNC + H_BP);
  localparam logic [HW-1:0] H_OFF  = HW'(H_SYNC + H_BP + H_VIS);
  localparam logic [VW-1:0] V_ON   = VW'(V_SYNC + V_BP);
  localparam logic [VW-1:0] V_OFF  = VW'(V_SYNC + V_BP + V_VIS);

  logic          run;
  logic [HW-1:0] oh, oh_d;
  logic [VW-1:0] ov, ov_d;
  logic          cnt_en, line_end;

  always_comb begin
    line_end = (oh == H_LST);
    cnt_en   = run | start;
    if (!run) begin
      oh_d = H_INIT;
      ov_d = V_INIT;
    end else begin
      oh_d = line_end ? '0 : oh + 1'b1;
      if (line_end) ov_d = (ov == V_LST) ? '0 : ov + 1'b1;
      else          ov_d = ov;
    end
  end

  assign hs_n = ~(run & (oh < H_SW));
  assign vs_n = ~(run & (ov < V_SW));
  assign vis  = run & (oh >= H_ON) & (oh < H_OFF) & (ov >= V_ON) & (ov < V_OFF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0;
      oh  <= '0;
      ov  <= '0;
    end else if (cnt_en) begin
      run <= 1'b1;
      oh  <= oh_d;
      ov  <= ov_d;
    end
  end

endmodule

// File: rtl/ivga_pix_fifo.sv
// Pixel queue with combinational head; write and read may share a cycle.
module ivga_pix_fifo
  import ivga_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  pix_t wdata,
  input  logic rd,
  output pix_t rdata,
  output logic full,
  output logic empty
);

  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] P_LST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] C_MAX = CW'(DEPTH);

  pix_t          mem [DEPTH];
  logic [AW-1:0] wp, rp, wp_d, rp_d;
  logic [CW-1:0] cnt, cnt_d;
  logic          do_wr, do_rd;

  assign full  = (cnt == C_MAX);
  assign empty = (cnt == '0);
  assign rdata = mem[rp];

  always_comb begin
    do_rd = rd & ~empty;
    do_wr = wr & (~full | do_rd);
    wp_d  = (wp == P_LST) ? '0 : wp + 1'b1;
    rp_d  = (rp == P_LST) ? '0 : rp + 1'b1;
    cnt_d = cnt;
    if (do_wr & ~do_rd)      cnt_d = cnt + 1'b1;
    else if (do_rd & ~do_wr) cnt_d = cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_wr) wp <= wp_d;
      if (do_rd) rp <= rp_d;
      cnt <= cnt_d;
    end
  end

endmodule

// File: rtl/ivga_retimer.sv
module ivga_retimer
  import ivga_pkg::*;
#(
  parameter int H_VIS    = 640,
  parameter int H_FP     = 16,
  parameter int H_SYNC   = 96,
  parameter int H_BP     = 48,
  parameter int V_VIS    = 480,
  parameter int V_FP     = 10,
  parameter int V_SYNC   = 2,
  parameter int V_BP     = 33,
  parameter int OFFSET   = 32,
  parameter int QDEPTH   = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] i_red,
  input  logic [2:0] i_green,
  input  logic [2:0] i_blue,
  input  logic       i_hsync,
  input  logic       i_vsync,
  output logic [2:0] o_red,
  output logic [2:0] o_green,
  output logic [2:0] o_blue,
  output logic       o_hsync,
  output logic       o_vsync,
  output logic       o_error
);

  localparam int H_TOTAL = H_VIS + H_FP + H_SYNC + H_BP;
  localparam int V_TOTAL = V_VIS + V_FP + V_SYNC + V_BP;

  // reset: asserted at once, released on a clock edge
  logic rst_m, srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m  <= 1'b0;
      srst_n <= 1'b0;
    end else begin
      rst_m  <= 1'b1;
      srst_n <= rst_m;
    end
  end

  pix_t pix_in, pix_q, head, rgb_d, rgb_q;
  logic in_vis, lock_evt, locked, lost;
  logic ohs_n, ovs_n, out_vis;
  logic q_wr, q_rd, q_full, q_empty, ovf, udf, err_d;

  assign pix_in = '{r: i_red, g: i_green, b: i_blue};

  ivga_src_track #(
    .H_SYNC(H_SYNC), .H_BP(H_BP), .H_VIS(H_VIS), .H_TOTAL(H_TOTAL),
    .V_SYNC(V_SYNC), .V_BP(V_BP), .V_VIS(V_VIS), .V_TOTAL(V_TOTAL)
  ) i_src (
    .clk(clk), .rst_n(srst_n), .hsync_in(i_hsync), .vsync_in(i_vsync),
    .pix_in(pix_in), .pix_q(pix_q), .vis(in_vis), .lock_evt(lock_evt),
    .locked(locked), .lost(lost)
  );

  ivga_out_timing #(
    .H_SYNC(H_SYNC), .H_BP(H_BP), .H_VIS(H_VIS), .H_TOTAL(H_TOTAL),
    .V_SYNC(V_SYNC), .V_BP(V_BP), .V_VIS(V_VIS), .V_TOTAL(V_TOTAL),
    .OFFSET(OFFSET)
  ) i_otim (
    .clk(clk), .rst_n(srst_n), .start(lock_evt),
    .hs_n(ohs_n), .vs_n(ovs_n), .vis(out_vis)
  );

  assign q_wr = in_vis;
  assign q_rd = out_vis;

  ivga_pix_fifo #(.DEPTH(QDEPTH)) i_q (
    .clk(clk), .rst_n(srst_n), .wr(q_wr), .wdata(pix_q), .rd(q_rd),
    .rdata(head), .full(q_full), .empty(q_empty)
  );

  always_comb begin
    ovf   = q_wr & q_full & ~q_rd;
    udf   = q_rd & q_empty;
    err_d = o_error | lost | ovf | udf;
    rgb_d = (out_vis & ~q_empty) ? head : '0;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      o_hsync <= 1'b1;
      o_vsync <= 1'b1;
      rgb_q   <= '0;
      o_error <= 1'b0;
    end else begin
      o_hsync <= ohs_n;
      o_vsync <= ovs_n;
      rgb_q   <= rgb_d;
      o_error <= err_d;
    end
  end

  assign o_red   = rgb_q.r;
  assign o_green = rgb_q.g;
  assign o_blue  = rgb_q.b;

endmodule

// File: rtl/ivga_retimer_chk.sv
module ivga_retimer_chk (
  input logic       clk,
  input logic       srst_n,
  input logic       locked,
  input logic       lost,
  input logic       q_wr,
  input logic       q_rd,
  input logic       q_full,
  input logic       q_empty,
  input logic [2:0] o_red,
  input logic [2:0] o_green,
  input logic [2:0] o_blue,
  input logic       o_hsync,
  input logic       o_vsync,
  input logic       o_error
);

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!srst_n)
    o_error |=> o_error);

  // R5
  blank_in_hsync_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !o_hsync |-> ({o_red, o_green, o_blue} == 9'd0));

  // R5
  blank_in_vsync_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !o_vsync |-> ({o_red, o_green, o_blue} == 9'd0));

  // R2
  idle_before_lock_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !locked |=> (o_hsync && o_vsync && ({o_red, o_green, o_blue} == 9'd0)));

  // R3
  vsync_with_hsync_chk: assert property (@(posedge clk) disable iff (!srst_n)
    $fell(o_vsync) |-> !o_hsync);

  // R8
  overflow_err_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (q_wr && q_full && !q_rd) |=> o_error);

  // R8
  underflow_err_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (q_rd && q_empty) |=> o_error);

  // R6 R7
  lost_sync_err_chk: assert property (@(posedge clk) disable iff (!srst_n)
    lost |=> o_error);

endmodule

bind ivga_retimer ivga_retimer_chk i_chk (
  .clk(clk), .srst_n(srst_n), .locked(locked), .lost(lost),
  .q_wr(q_wr), .q_rd(q_rd), .q_full(q_full), .q_empty(q_empty),
  .o_red(o_red), .o_green(o_green), .o_blue(o_blue),
  .o_hsync(o_hsync), .o_vsync(o_vsync), .o_error(o_error)
);

// File: tb/test_ivga_retimer.sv
module test_ivga_retimer;

  localparam int CLK_PERIOD = 10;
  localparam int HV = 8, HF = 2, HS = 3, HB = 2;
  localparam int VV = 4, VF = 1, VS = 1, VB = 2;
  localparam int HT = HV + HF + HS + HB;
  localparam int VT = VV + VF + VS + VB;
  localparam int OFS = 5;
  localparam int DEPTH = 8;
  localparam int LAT = OFS + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] i_red = '0, i_green = '0, i_blue = '0;
  logic i_hsync = 1'b1, i_vsync = 1'b1;
  logic [2:0] o_red, o_green, o_blue;
  logic o_hsync, o_vsync, o_error;

  always #(CLK_PERIOD/2) clk = ~clk;

  ivga_retimer #(
    .H_VIS(HV), .H_FP(HF), .H_SYNC(HS), .H_BP(HB),
    .V_VIS(VV), .V_FP(VF), .V_SYNC(VS), .V_BP(VB),
    .OFFSET(OFS), .QDEPTH(DEPTH)
  ) i_ivga_retimer (
    .clk(clk), .rst_n(rst_n), .i_red(i_red), .i_green(i_green), .i_blue(i_blue),
    .i_hsync(i_hsync), .i_vsync(i_vsync), .o_red(o_red), .o_green(o_green),
    .o_blue(o_blue), .o_hsync(o_hsync), .o_vsync(o_vsync), .o_error(o_error)
  );

  typedef struct {
    bit         hs;
    bit         vs;
    logic [8:0] rgb;
    bit         vis;
    bit         lk;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  bit   mon_on = 0;
  bit   drv_locked = 0;
  bit   done = 0;

  task automatic chk(input string tag, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [8:0] pix_val(input int seed, input int line, input int pos);
    if (seed < 0) return 9'h1FF;
    return 9'((seed * 53 + line * 29 + pos * 7) & 511);
  endfunction

  // driver: one input line; pushes the expected output tuple for every clock
  task automatic drive_line(input int line, input int len, input bit vs_en, input int seed);
    for (int pos = 0; pos < len; pos++) begin
      bit hs, vs, vis;
      logic [8:0] px;
      exp_t e;
      @(negedge clk);
      hs  = !(pos < HS);
      vs  = !(vs_en && line < VS);
      vis = (pos >= HS + HB) && (pos < HS + HB + HV) &&
            (line >= VS + VB) && (line < VS + VB + VV);
      px  = vis ? pix_val(seed, line, pos) : (9'h155 ^ 9'(pos));
      i_hsync = hs;
      i_vsync = vs;
      {i_red, i_green, i_blue} = px;
      if (!vs) drv_locked = 1;
      e.hs  = drv_locked ? hs : 1'b1;
      e.vs  = drv_locked ? vs : 1'b1;
      e.rgb = (drv_locked && vis) ? px : 9'd0;
      e.vis = vis;
      e.lk  = drv_locked;
      if (mon_on) q.push_back(e);
    end
  endtask

  task automatic drive_frame(input int seed, input int len, input bit vs_en);
    for (int ln = 0; ln < VT; ln++) drive_line(ln, len, vs_en, seed);
  endtask

  // monitor: pops the item due this cycle and compares
  always begin
    exp_t e;
    @(posedge clk);
    #1;
    if (mon_on && q.size() >= LAT) begin
      e = q.pop_front();
      chk(e.lk ? "R3" : "R2", "syncs", {14'd0, o_hsync, o_vsync}, {14'd0, e.hs, e.vs});
      chk(!e.lk ? "R2" : (e.vis ? "R4" : "R5"), "rgb",
          {7'd0, o_red, o_green, o_blue}, {7'd0, e.rgb});
    end
  end

  task automatic do_reset();
    @(negedge clk);
    mon_on = 0;
    q.delete();
    drv_locked = 0;
    rst_n = 1'b0;
    i_hsync = 1'b1;
    i_vsync = 1'b1;
    {i_red, i_green, i_blue} = 9'h0;
    repeat (3) @(negedge clk);
    chk("R1", "idle in reset", {12'd0, o_hsync, o_vsync, |{o_red, o_green, o_blue}, o_error},
        16'b1100);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "idle after reset", {12'd0, o_hsync, o_vsync, |{o_red, o_green, o_blue}, o_error},
        16'b1100);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    // phase 1: scoreboard over a partial frame and several full frames
    do_reset();
    @(negedge clk);
    mon_on = 1;
    for (int ln = 5; ln < VT; ln++) drive_line(ln, HT, 1'b1, 0); // R2: discarded part
    drive_frame(1, HT, 1'b1);
    drive_frame(2, HT, 1'b1);
    drive_frame(-1, HT, 1'b1);
    drive_line(0, HT, 1'b1, 3);
    drive_line(1, HT, 1'b1, 3);
    chk("R9", "no error on clean stream", {15'd0, o_error}, 16'd0);
    mon_on = 0;
    q.delete();

    // phase 2: missing horizontal sync (R6), then stickiness (R9)
    do_reset();
    drive_frame(4, HT, 1'b1);
    chk("R6", "error before lost hsync", {15'd0, o_error}, 16'd0);
    drive_line(0, 2 * HT, 1'b1, 4);
    chk("R6", "error after lost hsync", {15'd0, o_error}, 16'd1);
    drive_frame(5, HT, 1'b1);
    chk("R9", "error held on clean input", {15'd0, o_error}, 16'd1);
    do_reset();
    chk("R9", "error cleared by reset", {15'd0, o_error}, 16'd0);

    // phase 3: missing vertical sync (R7)
    drive_frame(6, HT, 1'b1);
    chk("R7", "error before lost vsync", {15'd0, o_error}, 16'd0);
    drive_line(0, HT, 1'b0, 6);
    drive_line(1, HT, 1'b0, 6);
    chk("R7", "error after lost vsync", {15'd0, o_error}, 16'd1);

    // phase 4: short lines drift the input ahead of the output (R8)
    do_reset();
    drive_frame(7, HT, 1'b1);
    chk("R8", "error before short lines", {15'd0, o_error}, 16'd0);
    drive_frame(8, HT - 3, 1'b1);
    drive_frame(9, HT - 3, 1'b1);
    chk("R8", "error after queue overrun", {15'd0, o_error}, 16'd1);

    finish_run();
  end

endmodule